// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit RISC integer datapath. It takes one operand word and the current carry flag. It shifts the operand left, right, arithmetically right, or rotates it, or performs a one-place rotate through carry. It returns the shifted word and the carry bit that the shift produces. The whole path is combinational, so the outputs follow the inputs in the same cycle. Register reads, flag storage and instruction fetch are outside the block.

The shift can be specified in two ways. In register form, the caller supplies a 2-bit shift type and a register value, and the shift amount is the low byte of that value. In immediate form, the caller supplies the second halfword of a 32-bit instruction. The block extracts the 5-bit amount and the 2-bit type from fixed bit positions and decodes the zero-amount special cases itself. The carry-out is defined for every amount from 0 to 255, including exactly 32 and amounts above 32. Because the block is combinational and purely a data transform, it has no stream handshake.

Top module: `shf_unit`

## Requirements
- R1: When the effective amount is zero and the operation is not a rotate through carry, `shifted` equals `src_word` and `carry_out` equals `carry_flag`.
- R2: A left shift (type code 0) by n, with 1 ≤ n ≤ 31, gives `src_word << n` and a carry of `src_word[32-n]`. At n = 32 the result is zero and the carry is `src_word[0]`.
- R3: A left shift or a logical right shift by more than 32 gives a zero result and a zero carry.
- R4: A logical right shift (type code 1) by n, with 1 ≤ n ≤ 31, gives `src_word >> n` and a carry of `src_word[n-1]`. At n = 32 the result is zero and the carry is `src_word[31]`.
- R5: An arithmetic right shift (type code 2) by n, with 1 ≤ n ≤ 31, fills the vacated bits with `src_word[31]` and gives a carry of `src_word[n-1]`.
- R6: An arithmetic right shift by 32 or more fills every result bit with `src_word[31]` and gives a carry of `src_word[31]`.
- R7: A rotate right (type code 3) by a non-zero n rotates by n mod 32. The carry equals bit 31 of the result, so a non-zero multiple of 32 leaves the word unchanged and gives a carry of `src_word[31]`.
- R8: A rotate through carry gives `{carry_flag, src_word[31:1]}` and a carry of `src_word[0]`.
- R9: In register form (`amt_from_reg` = 1), the amount is `reg_amount[7:0]` and bits above bit 7 have no effect. `reg_shift_type` uses codes 0 = left, 1 = logical right, 2 = arithmetic right and 3 = rotate right. Register form never selects the rotate through carry.
- R10: In immediate form (`amt_from_reg` = 0), the amount is `{insn_half[14:12], insn_half[7:6]}` and the type is `insn_half[5:4]`, using the same codes as R9. All other bits of `insn_half` have no effect.
- R11: In immediate form with an amount field of zero, type 0 means no shift, types 1 and 2 mean a shift by 32, and type 3 selects a rotate through carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_word | input | 32 | Operand to be shifted |
| carry_flag | input | 1 | Current carry flag, used for a zero amount and for the rotate through carry |
| amt_from_reg | input | 1 | 1: take the type and amount from the register-form inputs; 0: decode them from `insn_half` |
| reg_shift_type | input | 2 | Register-form shift type (0 = left, 1 = logical right, 2 = arithmetic right, 3 = rotate right) |
| reg_amount | input | 32 | Register value whose low byte is the shift amount |
| insn_half | input | 16 | Second halfword of the 32-bit instruction that carries the immediate type and amount |
| shifted | output | 32 | Shifted result |
| carry_out | output | 1 | Carry produced by the shifter |

## Verification
The bench builds the block with its default parameters: a 32-bit word and an 8-bit amount. At that size it can sweep every register-form amount from 0 to 255 under all four type codes. It repeats the sweep for six operand patterns, both carry-in values, and with and without junk above bit 7 of the amount register. This reaches the 32 boundary, the region above 32 and the multiples of 32 for rotates. It also sweeps every immediate type and 5-bit amount, with junk in the unused instruction bits. This covers every zero-amount special case of the immediate decoder.

// File: rtl/shf_pkg.sv
package shf_pkg;
  // Internal operation selector; codes 0..3 match the external 2-bit type field.
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  // Width of the immediate amount field carried by the instruction.
  localparam int IMM_AMT_W = 5;
endpackage

// File: rtl/shf_imm_decode.sv
module shf_imm_decode
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [15:0]      insn_half,
  output shift_kind_e      kind,
  output logic [AMT_W-1:0] amount
);
  logic [IMM_AMT_W-1:0] imm_amt;
  logic [1:0]           imm_type;
  logic                 insn_unused;

  // Amount: upper three bits from [14:12], lower two from [7:6]; type from [5:4].
  assign imm_amt     = {insn_half[14:12], insn_half[7:6]};
  assign imm_type    = insn_half[5:4];
  assign insn_unused = ^{insn_half[15], insn_half[11:8], insn_half[3:0]};

  always_comb begin
    kind   = shift_kind_e'({1'b0, imm_type});
    amount = AMT_W'(imm_amt);
    if (imm_amt == '0) begin
      case (imm_type)
        2'd0: amount = '0;
        2'd3: begin
          kind   = SK_RRX;
          amount = AMT_W'(1);
        end
        default: amount = AMT_W'(WIDTH);
      endcase
    end
  end

  always_comb begin
    if (kind == SK_RRX) begin
      p_rrx_from_zero_ror_r11: assert (amount == AMT_W'(1) && imm_type == 2'd3);
    end
    if (amount == AMT_W'(WIDTH)) begin
      p_full_width_only_right_r11: assert (kind == SK_LSR || kind == SK_ASR);
    end
  end
endmodule

// File: rtl/shf_amt_mux.sv
module shf_amt_mux
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic             amt_from_reg,
  input  logic [1:0]       reg_shift_type,
  input  logic [WIDTH-1:0] reg_amount,
  input  shift_kind_e      imm_kind,
  input  logic [AMT_W-1:0] imm_amount,
  output shift_kind_e      kind,
  output logic [AMT_W-1:0] amount
);
  logic reg_hi_unused;

  // Only the low AMT_W bits of the register value count as an amount.
  assign reg_hi_unused = ^reg_amount[WIDTH-1:AMT_W];

  always_comb begin
    if (amt_from_reg) begin
      kind   = shift_kind_e'({1'b0, reg_shift_type});
      amount = reg_amount[AMT_W-1:0];
    end else begin
      kind   = imm_kind;
      amount = imm_amount;
    end
  end

  always_comb begin
    if (amt_from_reg) begin
      p_reg_never_rrx_r9: assert (kind != SK_RRX);
    end
  end
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] operand,
  input  logic             carry_in,
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amount,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int LW = $clog2(WIDTH);

  logic [LW-1:0]    lo;
  logic [LW-1:0]    idx_left;
  logic [LW-1:0]    idx_right;
  logic             at_or_past;
  logic             exactly_w;
  logic [WIDTH-1:0] rot;

  assign lo         = amount[LW-1:0];
  assign idx_left   = LW'(WIDTH - int'(lo));
  assign idx_right  = lo - LW'(1);
  assign at_or_past = (amount >= AMT_W'(WIDTH));
  assign exactly_w  = (amount == AMT_W'(WIDTH));
  assign rot        = (operand >> lo) | (operand << (WIDTH - int'(lo)));

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    if (kind == SK_RRX) begin
      result    = {carry_in, operand[WIDTH-1:1]};
      carry_out = operand[0];
    end else if (amount != '0) begin
      case (kind)
        SK_LSL: begin
          if (at_or_past) begin
            result    = '0;
            carry_out = exactly_w ? operand[0] : 1'b0;
          end else begin
            result    = operand << lo;
            carry_out = operand[idx_left];
          end
        end
        SK_LSR: begin
          if (at_or_past) begin
            result    = '0;
            carry_out = exactly_w ? operand[WIDTH-1] : 1'b0;
          end else begin
            result    = operand >> lo;
            carry_out = operand[idx_right];
          end
        end
        SK_ASR: begin
          if (at_or_past) begin
            result    = {WIDTH{operand[WIDTH-1]}};
            carry_out = operand[WIDTH-1];
          end else begin
            result    = $signed(operand) >>> lo;
            carry_out = operand[idx_right];
          end
        end
        SK_ROR: begin
          result    = rot;
          carry_out = rot[WIDTH-1];
        end
        default: begin
          result    = operand;
          carry_out = carry_in;
        end
      endcase
    end
  end

  always_comb begin
    if ((kind == SK_LSL || kind == SK_LSR) && amount > AMT_W'(WIDTH)) begin
      p_far_shift_zero_r3: assert (result == '0 && !carry_out);
    end
    if (kind == SK_ASR && at_or_past) begin
      p_asr_sign_fill_r6: assert (($countones(result) == 0 || $countones(result) == WIDTH)
                                  && carry_out == result[0]);
    end
    if (kind == SK_ROR && amount != '0) begin
      p_ror_carry_msb_r7: assert (carry_out == result[WIDTH-1]);
    end
    if (kind == SK_RRX) begin
      p_rrx_bits_r8: assert (result[WIDTH-2:0] == operand[WIDTH-1:1] && carry_out == operand[0]);
    end
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] src_word,
  input  logic             carry_flag,
  input  logic             amt_from_reg,
  input  logic [1:0]       reg_shift_type,
  input  logic [WIDTH-1:0] reg_amount,
  input  logic [15:0]      insn_half,
  output logic [WIDTH-1:0] shifted,
  output logic             carry_out
);
  shift_kind_e      imm_kind;
  logic [AMT_W-1:0] imm_amount;
  shift_kind_e      sel_kind;
  logic [AMT_W-1:0] sel_amount;

  shf_imm_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
    .insn_half (insn_half),
    .kind      (imm_kind),
    .amount    (imm_amount)
  );

  shf_amt_mux #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_mux (
    .amt_from_reg   (amt_from_reg),
    .reg_shift_type (reg_shift_type),
    .reg_amount     (reg_amount),
    .imm_kind       (imm_kind),
    .imm_amount     (imm_amount),
    .kind           (sel_kind),
    .amount         (sel_amount)
  );

  shf_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_core (
    .operand   (src_word),
    .carry_in  (carry_flag),
    .kind      (sel_kind),
    .amount    (sel_amount),
    .result    (shifted),
    .carry_out (carry_out)
  );

  always_comb begin
    if (sel_amount == '0 && sel_kind != SK_RRX) begin
      p_zero_passthrough_r1: assert (shifted == src_word && carry_out == carry_flag);
    end
  end
endmodule

// File: tb/shf_unit_tb_top.sv
module shf_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_word = '0;
  logic        carry_flag = 1'b0;
  logic        amt_from_reg = 1'b0;
  logic [1:0]  reg_shift_type = '0;
  logic [31:0] reg_amount = '0;
  logic [15:0] insn_half = '0;
  logic [31:0] shifted;
  logic        carry_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shf_unit dut_i (
    .src_word       (src_word),
    .carry_flag     (carry_flag),
    .amt_from_reg   (amt_from_reg),
    .reg_shift_type (reg_shift_type),
    .reg_amount     (reg_amount),
    .insn_half      (insn_half),
    .shifted        (shifted),
    .carry_out      (carry_out)
  );

  // Reference model: kind 0..3 = left, logical right, arithmetic right, rotate right; 4 = rotate through carry.
  function automatic void model(input logic [31:0] op, input int kind, input int n,
                                input logic cin, output logic [31:0] r, output logic c);
    r = op;
    c = cin;
    if (kind == 4) begin
      r = {cin, op[31:1]};
      c = op[0];
    end else if (n != 0) begin
      for (int i = 0; i < 32; i++) begin
        case (kind)
          0: r[i] = (i - n >= 0) ? op[i - n] : 1'b0;
          1: r[i] = (i + n <= 31) ? op[i + n] : 1'b0;
          2: r[i] = op[(i + n > 31) ? 31 : i + n];
          default: r[i] = op[(i + (n % 32)) % 32];
        endcase
      end
      case (kind)
        0: c = (n <= 32) ? op[32 - n] : 1'b0;
        1: c = (n <= 32) ? op[n - 1] : 1'b0;
        2: c = op[(n > 32) ? 31 : n - 1];
        default: c = r[31];
      endcase
    end
  endfunction

  function automatic string tag_for(input int kind, input int n);
    if (kind == 4) return "R8";
    if (n == 0) return "R1";
    case (kind)
      0: return (n > 32) ? "R3" : "R2";
      1: return (n > 32) ? "R3" : "R4";
      2: return (n >= 32) ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] exp_r, input logic exp_c);
    n_checks++;
    if (shifted !== exp_r || carry_out !== exp_c) begin
      n_fail++;
      $display("FAIL %s: got result=%08h carry=%0b, expected result=%08h carry=%0b",
               tag, shifted, carry_out, exp_r, exp_c);
    end
  endtask

  localparam logic [31:0] OPS [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                                      32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h1234_5678};

  initial begin
    logic [31:0] er;
    logic        ec;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'h0, 1'b0);  // idle inputs after reset: zero amount, zero operand

    // Register form sweep: every amount 0..255, all four type codes.
    for (int jk = 0; jk < 2; jk++) begin
      for (int oi = 0; oi < 6; oi++) begin
        for (int t = 0; t < 4; t++) begin
          for (int n = 0; n < 256; n++) begin
            for (int ci = 0; ci < 2; ci++) begin
              @(posedge clk);
              amt_from_reg   = 1'b1;
              src_word       = OPS[oi];
              carry_flag     = ci[0];
              reg_shift_type = t[1:0];
              reg_amount     = {(jk != 0) ? (24'h5A3C01 ^ 24'(n * 977)) : 24'h0, n[7:0]};
              insn_half      = 16'hFFFF;
              @(negedge clk);
              model(OPS[oi], t, n, ci[0], er, ec);
              check((jk != 0) ? "R9" : tag_for(t, n), er, ec);
            end
          end
        end
      end
    end

    // Immediate form sweep: every type and 5-bit amount, junk in unused bits.
    for (int oi = 0; oi < 6; oi++) begin
      for (int t = 0; t < 4; t++) begin
        for (int a = 0; a < 32; a++) begin
          for (int ci = 0; ci < 2; ci++) begin
            int kind;
            int n;
            logic [15:0] junk;
            junk = 16'(16'h9A5B * (oi + 1) ^ (a * 331) ^ (t * 4099));
            @(posedge clk);
            amt_from_reg   = 1'b0;
            src_word       = OPS[oi];
            carry_flag     = ci[0];
            reg_shift_type = 2'(t + 1);
            reg_amount     = 32'hFFFF_FF00 | 32'(a + 7);
            insn_half      = {junk[15], a[4:2], junk[11:8], a[1:0], t[1:0], junk[3:0]};
            @(negedge clk);
            kind = t;
            n    = a;
            if (a == 0) begin
              if (t == 3) begin kind = 4; n = 1; end
              else if (t != 0) n = 32;
            end
            model(OPS[oi], kind, n, ci[0], er, ec);
            check((a == 0) ? "R11" : "R10", er, ec);
          end
        end
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion within 150000 cycles");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule